// File: doc/BRIEF.md
# Infrared link mode configuration gate

This block holds the configuration word of an infrared link controller and guards the moment at which mode changes reach the physical layer. Software writes a 16-bit configuration word and, through a separate strobe, a 16-bit enable word. The encoding-mode selects and the CRC-width select stay pending in the configuration word. They reach an active copy only when the physical-layer enable bit goes from 0 to 1. A mode change therefore needs the enable bit cleared, the new word written, and the enable bit set again.

The block reports a status word. It holds the enable bit, a flag for an illegal mode combination, the active mode, and the effective transmit and receive enables. It also brings out the master run enable for the ring engine. When that master bit is cleared, the block sends a single-cycle reset pulse to the descriptor ring pointers.

Top module: `ir_cfg_gate`

## Requirements
- R1: The configuration word keeps only loopback (bit 14), transmit enable (bit 12), receive enable (bit 11), master (bit 10), receive-any (bit 9), CRC16 (bit 7), fast mode (bit 6), medium mode (bit 5), slow mode (bit 4), transmit polarity (bit 1) and receive polarity (bit 0). All other bits read back as 0 on `cfg_o`. Reset clears the word.
- R2: The mode bits 6..4 and CRC16 enter the active copy only in the cycle where a write sets enable bit 15 while it was 0. Configuration writes at any other time change only the pending word.
- R3: Status layout on `stat_o`: bit 15 is the enable, bit 14 the configuration error, bit 13 fast on, bit 12 medium on, bit 11 slow on, bit 10 active CRC16, bit 9 transmit active and bit 8 receive active. Bits 7..0 are 0. Only bit 15 of an enable write is stored.
- R4: While the enable is 0, status bits 13..10 read 0.
- R5: If more than one of bits 6..4 is set at an enable rise, the error bit sets and no mode-on bit is set. The error stays set until the next enable rise that finds a legal selection (zero or one mode bit).
- R6: Transmit active (status bit 9) always equals configuration bit 12.
- R7: Receive active (status bit 8) is set when bit 11 is set and either bit 12 is clear or bit 14 is set.
- R8: `mst_run_o` equals configuration bit 10. A write that takes bit 10 from 1 to 0 raises `ring_ptr_rst_o` for exactly the one cycle after that write. No other condition raises it.
- R9: When a configuration write and an enable rise occur in the same cycle, the rise latches the word stored before that cycle. The new word stays pending.
- R10: Writing the enable bit as 1 while it is already 1 does not latch the pending word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 16 | Configuration word write data |
| en_we_i | input | 1 | Enable word write strobe |
| en_wdata_i | input | 16 | Enable word write data (bit 15 used) |
| cfg_o | output | 16 | Pending configuration word readback |
| stat_o | output | 16 | Enable and status word |
| mst_run_o | output | 1 | Bus-master ring processing enable |
| ring_ptr_rst_o | output | 1 | One-cycle ring pointer reset pulse |

## Verification
Two functions can fall in the same cycle: the enable-rise latch and a configuration write. The bench strobes both writes in the same cycle, with a new mode in the written word that differs from the stored one. It judges the result by checking that the status shows the old mode while `cfg_o` shows the new word. The same stimulus also clears the master bit. This confirms that the ring reset pulse appears in the following cycle and is not disturbed by the latch.

// File: rtl/ir_cfg_pkg.sv
package ir_cfg_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned B_LOOP   = 14;
  localparam int unsigned B_TXEN   = 12;
  localparam int unsigned B_RXEN   = 11;
  localparam int unsigned B_MSTR   = 10;
  localparam int unsigned B_CRC16  = 7;
  localparam int unsigned B_FAST   = 6;
  localparam int unsigned B_MED    = 5;
  localparam int unsigned B_SLOW   = 4;
  localparam int unsigned B_PHYEN  = 15;
  localparam logic [WORD_W-1:0] CFG_MASK = 16'h5EF3;

  typedef struct packed {
    logic fast;
    logic med;
    logic slow;
    logic crc16;
  } mode_t;
endpackage

// File: rtl/ir_cfg_reg.sv
module ir_cfg_reg
  import ir_cfg_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] MASK = CFG_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/ir_mode_latch.sv
module ir_mode_latch
  import ir_cfg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_we_i,
  input  logic  en_bit_i,
  input  mode_t pend_i,
  output logic  en_o,
  output mode_t act_o,
  output logic  err_o
);
  logic  en_q, err_q;
  mode_t act_q;
  logic  rise;
  logic  multi;

  assign rise  = en_we_i && en_bit_i && !en_q;
  assign multi = ({1'b0, pend_i.fast} + {1'b0, pend_i.med} + {1'b0, pend_i.slow}) > 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      act_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_bit_i;
      if (rise) begin
        err_q <= multi;
        // illegal selection: no encoder is switched on
        act_q <= multi ? '{fast: 1'b0, med: 1'b0, slow: 1'b0, crc16: pend_i.crc16} : pend_i;
      end
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
  assign err_o = err_q;
endmodule

// File: rtl/ir_ring_rst.sv
module ir_ring_rst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mstr_i,
  output logic pulse_o
);
  logic mstr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mstr_d <= 1'b0;
    else         mstr_d <= mstr_i;
  end

  assign pulse_o = mstr_d && !mstr_i;
endmodule

// File: rtl/ir_cfg_gate.sv
module ir_cfg_gate
  import ir_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic        en_we_i,
  input  logic [15:0] en_wdata_i,
  output logic [15:0] cfg_o,
  output logic [15:0] stat_o,
  output logic        mst_run_o,
  output logic        ring_ptr_rst_o
);
  logic [WORD_W-1:0] cfg_q;
  mode_t pend, act;
  logic  en_q, err_q, tx_act, rx_act, gate;

  ir_cfg_reg #(.W(WORD_W), .MASK(CFG_MASK)) u_reg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .q_o(cfg_q)
  );

  assign pend = '{fast: cfg_q[B_FAST], med: cfg_q[B_MED],
                  slow: cfg_q[B_SLOW], crc16: cfg_q[B_CRC16]};

  ir_mode_latch u_latch (
    .clk_i, .rst_ni, .en_we_i, .en_bit_i(en_wdata_i[B_PHYEN]),
    .pend_i(pend), .en_o(en_q), .act_o(act), .err_o(err_q)
  );

  ir_ring_rst u_rrst (
    .clk_i, .rst_ni, .mstr_i(cfg_q[B_MSTR]), .pulse_o(ring_ptr_rst_o)
  );

  assign tx_act    = cfg_q[B_TXEN];
  assign rx_act    = cfg_q[B_RXEN] && (!cfg_q[B_TXEN] || cfg_q[B_LOOP]);
  assign gate      = en_q;
  assign cfg_o     = cfg_q;
  assign mst_run_o = cfg_q[B_MSTR];
  assign stat_o    = {en_q, err_q,
                      gate & act.fast, gate & act.med, gate & act.slow, gate & act.crc16,
                      tx_act, rx_act, 8'h00};
endmodule

module ir_cfg_gate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cfg_o,
  input logic [15:0] stat_o,
  input logic        mst_run_o,
  input logic        ring_ptr_rst_o
);
  p_tx_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[9] == cfg_o[12]);
  p_rx_rule_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[8] == (cfg_o[11] && (!cfg_o[12] || cfg_o[14])));
  p_modes_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[15] |-> stat_o[13:10] == 4'b0);
  p_mode_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_o[13:11]));
  p_err_no_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[14] |-> stat_o[13:11] == 3'b0);
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[15] && $past(stat_o[15])) |-> $stable(stat_o[14:10]));
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ptr_rst_o |=> !ring_ptr_rst_o);
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ptr_rst_o |-> !mst_run_o && $fell(mst_run_o));
  p_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & 16'hA10C) == 16'h0);
endmodule

bind ir_cfg_gate ir_cfg_gate_chk u_chk (
  .clk_i, .rst_ni, .cfg_o, .stat_o, .mst_run_o, .ring_ptr_rst_o
);

// File: tb/ir_cfg_gate_test.sv
module ir_cfg_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, en_we = 1'b0;
  logic [15:0] cfg_wd = '0, en_wd = '0;
  logic [15:0] cfg_o, stat_o;
  logic        mst_run, ring_rst;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ir_cfg_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .en_we_i(en_we), .en_wdata_i(en_wd), .cfg_o(cfg_o), .stat_o(stat_o),
    .mst_run_o(mst_run), .ring_ptr_rst_o(ring_rst)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, strobes cover one posedge, sample at following negedge
  task automatic wr(input bit wc, input logic [15:0] c, input bit we, input logic [15:0] e);
    @(negedge clk);
    cfg_we = wc; cfg_wd = c; en_we = we; en_wd = e;
    @(negedge clk);
    cfg_we = 1'b0; en_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset cfg", cfg_o, 16'h0000);
    chk("R3 reset stat", stat_o, 16'h0000);
    chk("R8 reset pulse", {15'b0, ring_rst}, 16'h0);
  endtask

  task automatic t_mask;
    wr(1, 16'hFFFF, 0, 0);
    chk("R1 mask", cfg_o, 16'h5EF3);
    chk("R2 no latch while off", stat_o & 16'hFC00, 16'h0000);
    chk("R4 modes off", stat_o[13:10], 4'h0);
    wr(1, 16'h0000, 0, 0);
  endtask

  task automatic t_latch;
    wr(1, 16'h0040 | 16'h0080, 0, 0);
    wr(0, 0, 1, 16'h8000);
    chk("R2 fast latched", stat_o & 16'hFC00, 16'hA400);
    wr(1, 16'h0010, 0, 0);
    chk("R2 write while on pending", stat_o & 16'hFC00, 16'hA400);
    chk("R1 pending readback", cfg_o, 16'h0010);
    wr(0, 0, 1, 16'hFFFF);
    chk("R10 no relatch", stat_o & 16'hFC00, 16'hA400);
    chk("R3 only bit15 stored", stat_o[7:0], 16'h0);
    wr(0, 0, 1, 16'h0000);
    chk("R4 off clears modes", stat_o & 16'hFC00, 16'h0000);
    wr(0, 0, 1, 16'h8000);
    chk("R2 slow latched", stat_o & 16'hFC00, 16'h8800);
    wr(0, 0, 1, 16'h0000);
  endtask

  task automatic t_err;
    wr(1, 16'h0060, 0, 0);
    wr(0, 0, 1, 16'h8000);
    chk("R5 error set", stat_o & 16'hFC00, 16'hC000);
    wr(0, 0, 1, 16'h0000);
    chk("R5 error held off", stat_o & 16'hFC00, 16'h4000);
    wr(1, 16'h0020, 0, 0);
    wr(0, 0, 1, 16'h8000);
    chk("R5 error cleared", stat_o & 16'hFC00, 16'h9000);
    wr(0, 0, 1, 16'h0000);
  endtask

  task automatic t_txrx;
    wr(1, 16'h1000, 0, 0); chk("R6 tx only", stat_o[9:8], 16'h2);
    wr(1, 16'h0800, 0, 0); chk("R7 rx only", stat_o[9:8], 16'h1);
    wr(1, 16'h1800, 0, 0); chk("R7 tx blocks rx", stat_o[9:8], 16'h2);
    wr(1, 16'h5800, 0, 0); chk("R7 loop keeps rx", stat_o[9:8], 16'h3);
    wr(1, 16'h4000, 0, 0); chk("R6 none", stat_o[9:8], 16'h0);
  endtask

  task automatic t_ring;
    wr(1, 16'h0400, 0, 0);
    chk("R8 run on", {15'b0, mst_run}, 16'h1);
    chk("R8 no pulse on set", {15'b0, ring_rst}, 16'h0);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = 16'h0000;
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    chk("R8 pulse high", {15'b0, ring_rst}, 16'h1);
    chk("R8 run off", {15'b0, mst_run}, 16'h0);
    @(negedge clk);
    chk("R8 pulse one cycle", {15'b0, ring_rst}, 16'h0);
  endtask

  task automatic t_same;
    wr(1, 16'h0440, 0, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wd = 16'h0010; en_we = 1'b1; en_wd = 16'h8000;
    @(posedge clk); #1 cfg_we = 1'b0; en_we = 1'b0;
    @(negedge clk);
    chk("R9 old word latched", stat_o & 16'hFC00, 16'hA000);
    chk("R9 new word pending", cfg_o, 16'h0010);
    chk("R8 pulse with latch", {15'b0, ring_rst}, 16'h1);
    @(negedge clk);
    chk("R8 pulse ends", {15'b0, ring_rst}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_mask; t_latch; t_err; t_txrx; t_ring; t_same;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule